// File: doc/BRIEF.md
# Three-Wire Host Command Port

This block is the slave end of a three-wire serial link through which a host microcontroller reaches the register space of a servo controller. The host drives a serial clock, a bidirectional data line and a load line. The host clock may be fully asynchronous to the system clock. All three inputs are brought into the system clock domain through synchronisers, and every edge is detected there. Bytes move MSB first, and the data line is sampled on each rising edge of the host clock.

Every exchange opens with a command byte from the host. Bit 7 of that byte selects the direction: 1 is a read and 0 is a write. Bits 3:0 give the first register address, and the address steps up by one (wrapping from 15 to 0) after each data byte. Bits 6:4 matter only for writes and give how many data bytes, up to seven, the block forwards to the register-file write port. A read runs for as many bytes as the host clocks out, up to 128. The block fetches each byte from the register-file read port before the host needs it.

The load line frames the exchange. The host holds it low while it clocks the bits of a byte and raises it to mark the end of that byte. A marker that follows exactly eight bits completes the byte. A marker that follows no bits closes the whole exchange. A marker that follows any other number of bits drops the partial byte and raises a sticky error flag.

Top module: `hsi_host_port`

## Requirements
- R1: A byte is exactly the 8 data-line values sampled at the host clock rising edges while the load line is low, taken MSB first; a rising load line after those 8 bits completes it.
- R2: The first complete byte of an exchange is the command: bit 7 = 1 for read and 0 for write, bits 6:4 = write byte count, bits 3:0 = start address.
- R3: In a write, each of the first count data bytes produces one register write pulse, to the start address and then to consecutive addresses that wrap from 15 to 0.
- R4: Data bytes beyond the write count produce no register write.
- R5: A write command with count 0 produces no register write.
- R6: In a read, the register at the start address is fetched when the command completes, and the next register is fetched as each read byte completes. Each fetched byte is driven on the data line MSB first, one bit per host clock rising edge.
- R7: The data-line enable is high only from completion of a read command until the exchange closes. It is low during writes, during the command byte and while idle.
- R8: After the 128th read byte completes, the data line is released and no further fetch occurs in that exchange.
- R9: A load-line marker after 1 to 7 bits (or more than 8) discards the byte without a write or an address step, and sets the error flag. Only reset clears the flag.
- R10: A load-line marker with no bits since the previous marker ends the exchange; the next complete byte is decoded as a new command.
- R11: After reset, no write or fetch pulse is issued, the data line is released and the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_clk | input | 1 | Host serial clock, asynchronous |
| hs_din | input | 1 | Data line value seen from the pad |
| hs_load | input | 1 | Load line: low while bits are clocked, rising marks end of byte |
| hs_dout | output | 1 | Data line value driven during reads |
| hs_doe | output | 1 | Data line output enable |
| reg_wr_en | output | 1 | One-cycle register write pulse |
| reg_wr_addr | output | 4 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_en | output | 1 | One-cycle register fetch pulse |
| reg_rd_addr | output | 4 | Register fetch address |
| reg_rd_data | input | 8 | Register fetch data, valid in the cycle of the fetch pulse |
| frame_err | output | 1 | Sticky flag for a byte cut short by a marker |

## Verification
A corrupt bit counter or shift register shows up at the next load-line marker. It appears either as a write carrying the wrong data or address, or as a missing write together with a raised error flag. In both cases it is visible within one byte time. A wrong address pointer or a lost write count shows at the next register pulse. A read/write state that fails to clear at the end of an exchange shows as a data-line enable still high, or as a stray write or fetch, on the next command byte. The 128-byte cap is seen only at the very end of a long read: the enable stays high and a 129th fetch appears.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 3;

  typedef struct packed {
    logic              is_read;
    logic [CNT_W-1:0]  wr_count;
    logic [ADDR_W-1:0] start;
  } hsi_cmd_t;

  typedef enum logic [1:0] {ST_CMD, ST_WRITE, ST_READ} hsi_state_t;

  // command byte: [7] direction, [6:4] write count, [3:0] first address
  function automatic hsi_cmd_t hsi_decode(input logic [BYTE_W-1:0] b);
    return hsi_cmd_t'(b);
  endfunction

  // register pointer advance, wraps at the top of the address space
  function automatic logic [ADDR_W-1:0] hsi_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/hsi_sync.sv
module hsi_sync #(
  parameter int         W      = 3,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= INIT;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= INIT;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsi_shift.sv
module hsi_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  input  logic         mark,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] rx_byte,
  output logic         tx_msb,
  output logic         byte_ok,
  output logic         byte_short,
  output logic         byte_none
);
  localparam int BC_W = $clog2(W + 2);

  logic [BC_W-1:0] bits;
  logic [W-1:0]    tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits    <= '0;
      rx_byte <= '0;
      tx      <= '0;
    end else begin
      if (mark)
        bits <= '0;
      else if (shift_en && bits <= BC_W'(W))
        bits <= bits + 1'b1;
      if (shift_en)
        rx_byte <= {rx_byte[W-2:0], din};
      if (load_en)
        tx <= load_val;
      else if (shift_en)
        tx <= {tx[W-2:0], 1'b0};
    end
  end

  assign tx_msb     = tx[W-1];
  assign byte_none  = (bits == '0);
  assign byte_ok    = (bits == BC_W'(W));
  assign byte_short = !byte_none && !byte_ok;

  // a marker and a bit never arrive in the same cycle
  p_mark_no_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> !shift_en);
  // fetched data is loaded only at a byte boundary
  p_load_at_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> mark);
endmodule

// File: rtl/hsi_host_port.sv
module hsi_host_port
  import hsi_pkg::*;
#(
  parameter int RD_MAX      = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_clk,
  input  logic              hs_din,
  input  logic              hs_load,
  output logic              hs_dout,
  output logic              hs_doe,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [BYTE_W-1:0] reg_rd_data,
  output logic              frame_err
);
  localparam int RN_W = $clog2(RD_MAX + 1);

  // synchronised host lines: {load, data, clock}
  logic [2:0] pins_s;
  hsi_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({hs_load, hs_din, hs_clk}), .q(pins_s)
  );

  logic sck_prev, ld_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_prev <= 1'b0;
      ld_prev  <= 1'b1;
    end else begin
      sck_prev <= pins_s[0];
      ld_prev  <= pins_s[2];
    end

  // named events for the assertions
  wire sck_rise = pins_s[0] & ~sck_prev;
  wire ld_rise  = pins_s[2] & ~ld_prev;
  wire shift_en = sck_rise & ~pins_s[2];

  logic [BYTE_W-1:0] rx_byte;
  logic              byte_ok, byte_short, byte_none;
  logic              fetch;
  logic [ADDR_W-1:0] fetch_addr;

  hsi_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(pins_s[1]),
    .mark(ld_rise), .load_en(fetch), .load_val(reg_rd_data),
    .rx_byte(rx_byte), .tx_msb(hs_dout),
    .byte_ok(byte_ok), .byte_short(byte_short), .byte_none(byte_none)
  );

  hsi_state_t        state;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  wr_left;
  logic [RN_W-1:0]   rd_num;
  logic              rd_live;

  wire      byte_done = ld_rise & byte_ok;
  hsi_cmd_t cmd;
  assign cmd = hsi_decode(rx_byte);

  always_comb begin
    fetch      = 1'b0;
    fetch_addr = ptr;
    if (byte_done) begin
      if (state == ST_CMD && cmd.is_read) begin
        fetch      = 1'b1;
        fetch_addr = cmd.start;
      end else if (state == ST_READ && rd_live && rd_num < RN_W'(RD_MAX)) begin
        fetch = 1'b1;
      end
    end
  end

  assign reg_rd_en   = fetch;
  assign reg_rd_addr = fetch_addr;
  assign hs_doe      = rd_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_CMD;
      ptr         <= '0;
      wr_left     <= '0;
      rd_num      <= '0;
      rd_live     <= 1'b0;
      frame_err   <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      if (ld_rise && byte_none) begin
        state   <= ST_CMD;
        rd_live <= 1'b0;
      end
      if (ld_rise && byte_short)
        frame_err <= 1'b1;
      if (byte_done) begin
        unique case (state)
          ST_CMD: begin
            if (cmd.is_read) begin
              state   <= ST_READ;
              ptr     <= hsi_step(cmd.start);
              rd_num  <= RN_W'(1);
              rd_live <= 1'b1;
            end else begin
              state   <= ST_WRITE;
              ptr     <= cmd.start;
              wr_left <= cmd.wr_count;
            end
          end
          ST_WRITE: begin
            if (wr_left != '0) begin
              reg_wr_en   <= 1'b1;
              reg_wr_addr <= ptr;
              reg_wr_data <= rx_byte;
              ptr         <= hsi_step(ptr);
              wr_left     <= wr_left - 1'b1;
            end
          end
          ST_READ: begin
            if (fetch) begin
              ptr    <= hsi_step(ptr);
              rd_num <= rd_num + 1'b1;
            end else begin
              rd_live <= 1'b0;
            end
          end
          default: state <= ST_CMD;
        endcase
      end
    end
  end

  // the data line is released only at a load-line marker
  p_release_at_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_doe) |-> $past(ld_rise));
  // every fetch is followed by driving the data line
  p_fetch_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> hs_doe);
  // the error flag never clears while out of reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  // register writes and fetches never overlap
  p_no_rw_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_en, reg_rd_en}));
  // a write pulse only follows a byte taken in the write phase
  p_wr_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> ($past(state) == ST_WRITE && $past(ld_rise)));
endmodule

// File: tb/hsi_host_port_test.sv
module hsi_host_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       hs_clk = 1'b0, hs_din = 1'b0, hs_load = 1'b1;
  logic       hs_dout, hs_doe, reg_wr_en, reg_rd_en, frame_err;
  logic [3:0] reg_wr_addr, reg_rd_addr;
  logic [7:0] reg_wr_data, reg_rd_data;

  hsi_host_port uut (
    .clk(clk), .rst_n(rst_n), .hs_clk(hs_clk), .hs_din(hs_din),
    .hs_load(hs_load), .hs_dout(hs_dout), .hs_doe(hs_doe),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .frame_err(frame_err)
  );

  logic [7:0] mem [16];
  logic [7:0] shadow [16];
  assign reg_rd_data = mem[reg_rd_addr];
  always @(posedge clk) if (reg_wr_en) mem[reg_wr_addr] <= reg_wr_data;

  typedef struct { logic [3:0] a; logic [7:0] d; } wr_t;
  wr_t        wq[$];
  logic [7:0] rq[$];
  wr_t        got;
  int total = 0, bad = 0, n_wr = 0, n_rd = 0;
  int H = 5;
  bit done = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor for register writes
  always @(negedge clk) begin
    if (reg_wr_en) begin
      n_wr++;
      total++;
      if (wq.size() == 0) begin
        bad++;
        $display("FAIL R4: actual=write a%0d d%0h expected=no write", reg_wr_addr, reg_wr_data);
      end else begin
        got = wq.pop_front();
        if (got.a != reg_wr_addr || got.d != reg_wr_data) begin
          bad++;
          $display("FAIL R3: actual=a%0d d%0h expected=a%0d d%0h",
                   reg_wr_addr, reg_wr_data, got.a, got.d);
        end
      end
    end
    if (reg_rd_en) n_rd++;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic put_bit(logic b);
    hs_din = b; tick(H);
    hs_clk = 1'b1; tick(H);
    hs_clk = 1'b0;
  endtask

  task automatic open_byte();  hs_load = 1'b0; tick(H); endtask
  task automatic close_byte(); tick(H); hs_load = 1'b1; tick(H); endtask

  task automatic send_byte(logic [7:0] v);
    open_byte();
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    close_byte();
  endtask

  task automatic send_short(int n);
    open_byte();
    for (int i = 0; i < n; i++) put_bit(i[0]);
    close_byte();
  endtask

  task automatic end_xfer(); open_byte(); close_byte(); endtask

  task automatic expect_wr(logic [3:0] a, logic [7:0] d);
    wr_t e;
    e.a = a; e.d = d;
    wq.push_back(e);
    shadow[a] = d;
  endtask

  task automatic recv_check(string req);
    logic [7:0] v, e;
    open_byte();
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      v[i] = hs_dout;
      hs_clk = 1'b1; tick(H);
      hs_clk = 1'b0;
    end
    close_byte();
    e = rq.pop_front();
    check(v == e, req, v, e);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'(i * 37 + 5);
      shadow[i] = mem[i];
    end
    repeat (20000 * 10) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    tick(4);
    // R11: reset state
    check(hs_doe == 0, "R11 doe", hs_doe, 0);
    check(frame_err == 0, "R11 err", frame_err, 0);
    check(reg_wr_en == 0 && reg_rd_en == 0, "R11 pulses", reg_wr_en, 0);
    rst_n = 1'b1;
    tick(10);

    // R1 R2 R3: write 3 bytes from address 2 (cmd 0x32)
    send_byte(8'h32);
    check(hs_doe == 0, "R7 doe in write", hs_doe, 0);
    expect_wr(4'd2, 8'hA5); send_byte(8'hA5);
    expect_wr(4'd3, 8'h01); send_byte(8'h01);
    expect_wr(4'd4, 8'h80); send_byte(8'h80);
    end_xfer();
    check(wq.size() == 0, "R3 all written", wq.size(), 0);
    check(n_wr == 3, "R1 write count", n_wr, 3);

    // R3: address wrap, count 2 from 15 (cmd 0x2F)
    send_byte(8'h2F);
    expect_wr(4'd15, 8'h5A); send_byte(8'h5A);
    expect_wr(4'd0, 8'hC3);  send_byte(8'hC3);
    end_xfer();
    check(n_wr == 5, "R3 wrap count", n_wr, 5);

    // R5: count 0 (cmd 0x05)
    send_byte(8'h05); send_byte(8'h77); end_xfer();
    check(n_wr == 5, "R5 no write", n_wr, 5);

    // R4: count 1, extra bytes ignored (cmd 0x11)
    send_byte(8'h11);
    expect_wr(4'd1, 8'h3C); send_byte(8'h3C);
    send_byte(8'h99); send_byte(8'h42);
    end_xfer();
    check(n_wr == 6, "R4 extra ignored", n_wr, 6);

    // R10: exchange ended early, next byte is a command (cmd 0x36 then 0x1C)
    send_byte(8'h36);
    expect_wr(4'd6, 8'hE1); send_byte(8'hE1);
    end_xfer();
    send_byte(8'h1C);
    expect_wr(4'd12, 8'h5E); send_byte(8'h5E);
    end_xfer();
    check(n_wr == 8, "R10 new command", n_wr, 8);

    // R6 R7: read 4 bytes from address 2 (cmd 0x82)
    r0 = n_rd;
    open_byte();
    for (int i = 7; i >= 0; i--) put_bit(i == 7 || i == 1);
    check(hs_doe == 0, "R7 doe in command", hs_doe, 0);
    close_byte();
    check(hs_doe == 1, "R7 doe after read cmd", hs_doe, 1);
    for (int k = 0; k < 4; k++) rq.push_back(shadow[(2 + k) % 16]);
    for (int k = 0; k < 4; k++) recv_check("R6 read data");
    check(n_rd - r0 == 5, "R6 fetch count", n_rd - r0, 5);
    end_xfer();
    check(hs_doe == 0, "R7 released at end", hs_doe, 0);

    // R6: read wraps from 14 (cmd 0x8E)
    send_byte(8'h8E);
    for (int k = 0; k < 3; k++) rq.push_back(shadow[(14 + k) % 16]);
    for (int k = 0; k < 3; k++) recv_check("R6 read wrap");
    end_xfer();

    // R8: 128-byte cap (cmd 0x80)
    r0 = n_rd;
    send_byte(8'h80);
    for (int k = 0; k < 128; k++) rq.push_back(shadow[k % 16]);
    for (int k = 0; k < 128; k++) recv_check("R8 long read");
    check(hs_doe == 0, "R8 released after 128", hs_doe, 0);
    check(n_rd - r0 == 128, "R8 fetch count", n_rd - r0, 128);
    send_byte(8'h00);
    check(n_rd - r0 == 128, "R8 no 129th fetch", n_rd - r0, 128);
    check(hs_doe == 0, "R8 stays released", hs_doe, 0);
    end_xfer();

    // R9: short byte discarded inside a write (cmd 0x23)
    check(frame_err == 0, "R9 err clear before", frame_err, 0);
    w0 = n_wr;
    send_byte(8'h23);
    expect_wr(4'd3, 8'h11); send_byte(8'h11);
    send_short(5);
    check(frame_err == 1, "R9 err set", frame_err, 1);
    expect_wr(4'd4, 8'h22); send_byte(8'h22);
    end_xfer();
    check(n_wr - w0 == 2, "R9 short not written", n_wr - w0, 2);

    // R9: short command discarded, flag stays (cmd 0x1A)
    send_short(3);
    send_byte(8'h1A);
    expect_wr(4'd10, 8'h6E); send_byte(8'h6E);
    end_xfer();
    check(frame_err == 1, "R9 err sticky", frame_err, 1);
    check(wq.size() == 0, "R3 queue drained", wq.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule